// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block sits between a clocked host and an external asynchronous static RAM with a 20-bit address, a 4-bit bidirectional data bus and active-low select, output-enable and write-enable strobes. The host offers one word at a time over a valid/ready handshake. The controller turns each request into a strobe sequence. Every phase of that sequence lasts a whole number of clock cycles, set by parameters that the integrator derives by rounding the memory's nanosecond limits up to the clock period. A read returns its data with a single-cycle valid pulse.

All strobes and the data-bus drive enable leave the block straight from flip-flops, so they cannot glitch. The bidirectional pin is split into a drive value, a drive enable and a sampled input, and the pad cell joins them at chip level. Writes are ended by the write-enable strobe while chip select stays low, and output enable stays high for the whole write. The controller's own data drivers switch on one cycle after write enable falls and switch off one cycle after it rises. After every write, the chip is deselected for a turnaround window before the next access starts.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted and just after it, mem_ce_n, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0, rd_valid is 0 and req_ready is 1.
- R2: A request is taken only in a cycle where req_valid and req_ready are both 1. req_ready is 0 in every cycle in which mem_ce_n is 0. The request fields are ignored while req_ready is 0.
- R3: A read (req_write = 0) holds mem_ce_n and mem_oe_n at 0 with mem_we_n at 1 for exactly RD_CYC consecutive cycles, with the accepted address on mem_addr.
- R4: Read data is the value of mem_dq_in in the last cycle of the read window. It appears on rd_data with rd_valid = 1 for exactly one cycle, the cycle right after that window, which is RD_CYC cycles after the accepting clock edge.
- R5: A write (req_write = 1) keeps mem_ce_n at 0 and mem_oe_n at 1 throughout. mem_we_n is 1 for SETUP_CYC cycles, then 0 for WE_CYC cycles, then 1 for HOLD_CYC cycles, all in that order.
- R6: mem_dq_oe is 0 in the first cycle with mem_we_n at 0. It is 1 for the remaining write-enable cycles and for the first cycle after mem_we_n returns to 1, and 0 afterwards. While it is 1, mem_dq_out carries the accepted write data.
- R7: mem_dq_oe is never 1 in a cycle where mem_oe_n is 0.
- R8: mem_addr does not change while mem_ce_n stays 0. mem_ce_n returns to 1 for at least one cycle between two accesses.
- R9: After a write, mem_ce_n is 1 and req_ready is 0 for exactly TURN_CYC cycles before the controller is idle again. A read that follows a write therefore sees at least TURN_CYC+1 cycles in which neither side drives the bus.
- R10: A read returns the data most recently written to the same address through the strobe sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (20) | Word address |
| req_wdata | input | DATA_W (4) | Write data |
| rd_valid | output | 1 | One-cycle pulse marking rd_data valid |
| rd_data | output | DATA_W (4) | Read result |
| mem_addr | output | ADDR_W (20) | Address to the memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | DATA_W (4) | Value driven onto the data pins |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_in | input | DATA_W (4) | Value sampled from the data pins |

## Verification
The hardest case to reach from the ports is the hand-over of the shared data bus. A read issued right after a write must find the controller's drivers released and the turnaround window fully served. The host also tends to present new fields while the controller is still busy. The bench issues a fixed-seed random mix of reads and writes with zero-to-two-cycle gaps, so write-then-read pairs on the same and on different addresses occur often. It overwrites the request fields with junk while busy. A memory model commits data only on the rising write-enable edge and drives the bus only during a legal read, so a misplaced strobe or a late driver shows up as wrong read data or as a measured gap that is too short.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_READ   = 3'd1,
      PH_WSETUP = 3'd2,
      PH_WPULSE = 3'd3,
      PH_WHOLD  = 3'd4,
      PH_TURN   = 3'd5
   } phase_e;

   function automatic int unsigned max5(input int unsigned a, input int unsigned b,
                                        input int unsigned c, input int unsigned d,
                                        input int unsigned e);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      if (e > m) m = e;
      return m;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int unsigned CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned RD_CYC    = 2,
   parameter int unsigned SETUP_CYC = 1,
   parameter int unsigned WE_CYC    = 2,
   parameter int unsigned HOLD_CYC  = 1,
   parameter int unsigned TURN_CYC  = 1,
   parameter int unsigned CNT_W     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  logic             is_write,
   input  logic             done,
   output phase_e           phase,
   output phase_e           phase_nxt,
   output logic             load,
   output logic [CNT_W-1:0] load_val
);

   phase_e after_hold;

   generate
      if (RD_CYC < 1)    begin : g_chk_rd    $error("RD_CYC must be at least 1");    end
      if (SETUP_CYC < 1) begin : g_chk_setup $error("SETUP_CYC must be at least 1"); end
      if (WE_CYC < 2)    begin : g_chk_we    $error("WE_CYC must be at least 2");    end
      if (HOLD_CYC < 1)  begin : g_chk_hold  $error("HOLD_CYC must be at least 1");  end

      if (TURN_CYC > 0) begin : g_turn
         assign after_hold = PH_TURN;
      end else begin : g_no_turn
         assign after_hold = PH_IDLE;
      end
   endgenerate

   always_comb begin
      phase_nxt = phase;
      unique case (phase)
         PH_IDLE:   if (fire) phase_nxt = is_write ? PH_WSETUP : PH_READ;
         PH_READ:   if (done) phase_nxt = PH_IDLE;
         PH_WSETUP: if (done) phase_nxt = PH_WPULSE;
         PH_WPULSE: if (done) phase_nxt = PH_WHOLD;
         PH_WHOLD:  if (done) phase_nxt = after_hold;
         PH_TURN:   if (done) phase_nxt = PH_IDLE;
         default:   phase_nxt = PH_IDLE;
      endcase
   end

   always_comb begin
      load_val = '0;
      unique case (phase_nxt)
         PH_READ:   load_val = CNT_W'(RD_CYC - 1);
         PH_WSETUP: load_val = CNT_W'(SETUP_CYC - 1);
         PH_WPULSE: load_val = CNT_W'(WE_CYC - 1);
         PH_WHOLD:  load_val = CNT_W'(HOLD_CYC - 1);
         PH_TURN:   load_val = CNT_W'(TURN_CYC - 1);
         default:   load_val = '0;
      endcase
   end

   assign load = (phase_nxt != phase);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase <= PH_IDLE;
      else        phase <= phase_nxt;
   end

   // a write never jumps straight from setup to release
   a_r5_pulse_follows_setup: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WHOLD) |-> ($past(phase) == PH_WPULSE || $past(phase) == PH_WHOLD));

endmodule

// File: rtl/sram_pin_regs.sv
module sram_pin_regs
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  phase_e            phase,
   input  phase_e            phase_nxt,
   input  logic              fire,
   input  logic              done,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr   <= '0;
         mem_dq_out <= '0;
         mem_ce_n   <= 1'b1;
         mem_oe_n   <= 1'b1;
         mem_we_n   <= 1'b1;
         mem_dq_oe  <= 1'b0;
         rd_valid   <= 1'b0;
         rd_data    <= '0;
      end else begin
         if (fire) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
         end
         mem_ce_n  <= (phase_nxt == PH_IDLE) || (phase_nxt == PH_TURN);
         mem_oe_n  <= (phase_nxt != PH_READ);
         mem_we_n  <= (phase_nxt != PH_WPULSE);
         mem_dq_oe <= (phase == PH_WPULSE) &&
                      (phase_nxt == PH_WPULSE || phase_nxt == PH_WHOLD);
         rd_valid  <= (phase == PH_READ) && done;
         if ((phase == PH_READ) && done) rd_data <= mem_dq_in;
      end
   end

   a_r5_we_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_ce_n && mem_oe_n));

   a_r7_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   a_r6_quiet_at_we_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> !mem_dq_oe);

   a_r6_drive_at_we_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> mem_dq_oe);

   a_r6_release_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |=> !mem_dq_oe);

   a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned ADDR_W    = 20,
   parameter int unsigned DATA_W    = 4,
   parameter int unsigned RD_CYC    = 2,
   parameter int unsigned SETUP_CYC = 1,
   parameter int unsigned WE_CYC    = 2,
   parameter int unsigned HOLD_CYC  = 1,
   parameter int unsigned TURN_CYC  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   localparam int unsigned MAX_CYC = max5(RD_CYC, SETUP_CYC, WE_CYC, HOLD_CYC, TURN_CYC);
   localparam int unsigned CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

   phase_e           phase;
   phase_e           phase_nxt;
   logic             fire;
   logic             done;
   logic             load;
   logic [CNT_W-1:0] load_val;

   assign req_ready = (phase == PH_IDLE);
   assign fire      = req_valid && req_ready;

   sram_phase_timer #(.CNT_W(CNT_W)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .done     (done)
   );

   sram_seq_fsm #(
      .RD_CYC    (RD_CYC),
      .SETUP_CYC (SETUP_CYC),
      .WE_CYC    (WE_CYC),
      .HOLD_CYC  (HOLD_CYC),
      .TURN_CYC  (TURN_CYC),
      .CNT_W     (CNT_W)
   ) i_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (fire),
      .is_write  (req_write),
      .done      (done),
      .phase     (phase),
      .phase_nxt (phase_nxt),
      .load      (load),
      .load_val  (load_val)
   );

   sram_pin_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) i_pins (
      .clk        (clk),
      .rst_n      (rst_n),
      .phase      (phase),
      .phase_nxt  (phase_nxt),
      .fire       (fire),
      .done       (done),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .mem_dq_in  (mem_dq_in),
      .mem_addr   (mem_addr),
      .mem_ce_n   (mem_ce_n),
      .mem_oe_n   (mem_oe_n),
      .mem_we_n   (mem_we_n),
      .mem_dq_out (mem_dq_out),
      .mem_dq_oe  (mem_dq_oe),
      .rd_valid   (rd_valid),
      .rd_data    (rd_data)
   );

   a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_ce_n |-> !req_ready);

   a_r3_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (mem_we_n && !mem_ce_n));

endmodule

// File: tb/test_sram_async_ctrl.sv
`timescale 1ns/1ps
module test_sram_async_ctrl;

   localparam int unsigned AW    = 20;
   localparam int unsigned DW    = 4;
   localparam int unsigned T_RD  = 3;
   localparam int unsigned T_SU  = 1;
   localparam int unsigned T_WE  = 3;
   localparam int unsigned T_HD  = 2;
   localparam int unsigned T_TA  = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          rd_valid;
   logic [DW-1:0] rd_data;
   logic [AW-1:0] mem_addr;
   logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [DW-1:0] mem_dq_out;
   logic [DW-1:0] mem_dq_in;
   logic [DW-1:0] drive_val = '0;

   int unsigned n_chk = 0;
   int unsigned n_fail = 0;
   bit          finished = 1'b0;

   logic [DW-1:0] ref_mem [int unsigned];
   logic [DW-1:0] mdl_mem [int unsigned];
   logic [DW-1:0] cur_wdata = '0;

   always #10 clk = ~clk;

   sram_async_ctrl #(
      .ADDR_W(AW), .DATA_W(DW), .RD_CYC(T_RD), .SETUP_CYC(T_SU),
      .WE_CYC(T_WE), .HOLD_CYC(T_HD), .TURN_CYC(T_TA)
   ) i_sram_async_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
      .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   // memory model drives only during a legal read
   assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ? drive_val : '0;

   function automatic logic [DW-1:0] init_val(input logic [AW-1:0] a);
      return a[3:0] ^ a[7:4] ^ 4'hA;
   endfunction

   function automatic logic [DW-1:0] ref_get(input logic [AW-1:0] a);
      if (ref_mem.exists(int'(a))) return ref_mem[int'(a)];
      return init_val(a);
   endfunction

   function automatic logic [DW-1:0] mdl_get(input logic [AW-1:0] a);
      if (mdl_mem.exists(int'(a))) return mdl_mem[int'(a)];
      return init_val(a);
   endfunction

   task automatic chk(input bit ok, input string req, input int unsigned act, input int unsigned exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- pin monitor (samples at negedge) ----------------
   logic          p_ce_n = 1'b1, p_oe_n = 1'b1;
   logic [AW-1:0] p_addr = '0;
   bit            op_w = 1'b0;
   int unsigned   c_pre = 0, c_low = 0, c_post = 0, oe_run = 0;
   int unsigned   gap = 0, tcnt = 0;
   bit            tmon = 1'b0, last_was_w = 1'b0;
   logic [DW-1:0] last_wd = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         drive_val = mdl_get(mem_addr);
         // turnaround window after a write (R9)
         if (tmon) begin
            if (!req_ready) tcnt++;
            else begin
               chk(tcnt == T_TA, "R9 turnaround length", tcnt, T_TA);
               tmon = 1'b0;
            end
         end
         chk(!(mem_dq_oe && !mem_oe_n), "R7 contention", {mem_dq_oe, mem_oe_n}, 2'b11);
         if (!mem_ce_n) chk(!req_ready, "R2 ready low while busy", req_ready, 0);
         if (!mem_ce_n && !p_ce_n) chk(mem_addr == p_addr, "R8 address stable", mem_addr, p_addr);
         if (!mem_ce_n && p_ce_n) begin
            op_w = mem_oe_n; c_pre = 0; c_low = 0; c_post = 0;
         end
         // read strobe window (R3) and bus gap (R9)
         if (!mem_oe_n) begin
            if (p_oe_n && last_was_w)
               chk(gap >= T_TA + 1, "R9 undriven gap before read", gap, T_TA + 1);
            if (p_oe_n) last_was_w = 1'b0;
            oe_run++;
            chk(mem_we_n == 1'b1, "R3 we high in read", mem_we_n, 1);
         end else if (!p_oe_n) begin
            chk(oe_run == T_RD, "R3 read window length", oe_run, T_RD);
            oe_run = 0;
         end
         if (mem_dq_oe) gap = 0; else if (mem_oe_n) gap++;
         // write sequence (R5, R6) and memory commit
         if (!mem_ce_n && op_w) begin
            if (!mem_we_n) c_low++;
            else if (c_low == 0) c_pre++;
            else c_post++;
            chk(mem_oe_n == 1'b1, "R5 oe high in write", mem_oe_n, 1);
            chk(mem_dq_oe == ((!mem_we_n && c_low >= 2) || (mem_we_n && c_low != 0 && c_post == 1)),
                "R6 driver enable timing", mem_dq_oe,
                ((!mem_we_n && c_low >= 2) || (mem_we_n && c_low != 0 && c_post == 1)));
            if (mem_dq_oe) chk(mem_dq_out == cur_wdata, "R6 write data", mem_dq_out, cur_wdata);
            if (!mem_we_n && mem_dq_oe) last_wd = mem_dq_out;
            if (mem_we_n && c_post == 1) mdl_mem[int'(mem_addr)] = last_wd;
         end
         if (mem_ce_n && !p_ce_n && op_w) begin
            chk(c_pre == T_SU, "R5 setup cycles", c_pre, T_SU);
            chk(c_low == T_WE, "R5 write pulse cycles", c_low, T_WE);
            chk(c_post == T_HD, "R5 hold cycles", c_post, T_HD);
            chk(!mem_dq_oe, "R6 released after write", mem_dq_oe, 0);
            tmon = 1'b1; tcnt = 1; last_was_w = 1'b1; op_w = 1'b0;
         end
         p_ce_n = mem_ce_n; p_oe_n = mem_oe_n; p_addr = mem_addr;
      end
   end

   // ---------------- host tasks ----------------
   task automatic wait_ready();
      while (!req_ready) @(negedge clk);
   endtask

   task automatic host_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      wait_ready();
      req_write = 1'b1; req_addr = a; req_wdata = d; req_valid = 1'b1;
      cur_wdata = d; ref_mem[int'(a)] = d;
      @(negedge clk);
      req_valid = 1'b0;
      // R2: fields scrambled while busy must not matter
      req_addr = AW'($urandom); req_wdata = DW'($urandom); req_write = 1'(~$urandom);
   endtask

   task automatic host_read(input logic [AW-1:0] a);
      int unsigned n;
      logic [DW-1:0] exp;
      wait_ready();
      exp = ref_get(a);
      req_write = 1'b0; req_addr = a; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      req_addr = AW'($urandom); req_wdata = DW'($urandom);
      n = 0;
      while (!rd_valid && n < 40) begin @(negedge clk); n++; end
      chk(n == T_RD, "R4 read latency", n, T_RD);
      chk(rd_data == exp, "R10 read data", rd_data, exp);
      @(negedge clk);
      chk(!rd_valid, "R4 valid is one cycle", rd_valid, 0);
   endtask

   function automatic logic [AW-1:0] pick_addr();
      if ($urandom % 2) return AW'($urandom % 16);
      return AW'(20'hFFFF0 | ($urandom % 16));
   endfunction

   // ---------------- main sequence ----------------
   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes idle in reset", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
      chk(!mem_dq_oe, "R1 driver off in reset", mem_dq_oe, 0);
      chk(!rd_valid, "R1 no valid in reset", rd_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready, "R1 ready after reset", req_ready, 1);
      chk(mem_ce_n, "R1 deselected after reset", mem_ce_n, 1);

      // directed corners
      host_read(20'h00000);                 // unwritten location
      host_write(20'h00000, 4'h5);
      host_read(20'h00000);                 // read right after write, same address
      host_write(20'hFFFFF, 4'hF);
      host_write(20'hFFFFF, 4'h0);          // write after write
      host_read(20'hFFFFF);
      host_read(20'h00000);                 // read after read
      host_write(20'h00003, 4'h9);
      host_read(20'h00004);                 // read after write, other address
      host_read(20'h00003);

      // constrained random mix
      for (int i = 0; i < 200; i++) begin
         repeat ($urandom % 3) @(negedge clk);
         if ($urandom % 2) host_write(pick_addr(), DW'($urandom));
         else              host_read(pick_addr());
      end
      wait_ready();
      repeat (T_TA + 4) @(negedge clk);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog (all requirements) actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule